// File: doc/BRIEF.md
# Parallel Multi-Lane Waveform Synthesizer

This block is a direct digital synthesis source for arbitrary waveforms. It hands out a word of several samples every fabric clock, so that a serializer further down the chain can feed a converter that runs several times faster than any single table read. Each output word holds `LANES` consecutive samples of one scalar numerically controlled oscillator. A downstream serializer sends them out in lane order.

A wide phase accumulator moves forward by `LANES` times the frequency tuning word on each clock. Every lane adds its own fixed multiple of the tuning word to that base phase. The lane keeps the top `ADDR_W` bits of the sum as an address into its private copy of the waveform table. Because every lane has its own table copy, all lanes read at unrelated addresses in the same cycle. The multiples of the tuning word sit in registers, so a new frequency reaches every lane on the same cycle and the phase stays continuous.

A write port loads the waveform table, and one write updates every lane copy. A synchronous phase clear returns the accumulator to zero. The phase width defaults to 48 bits and the sample width to 14 bits. The address width is a parameter: it is 8 by default and 20 in a full-size build.

Top module: `mdds_multiphase`

## Requirements
- R1: While `rst` is high at a clock edge, `samples_vld` and `samples_out` are all zero after that edge. After `rst` falls, `samples_vld` stays low after the first edge and is high from the second edge onward, until the next reset.
- R2: Let P be a block's base phase and F its tuning word. Lane k of the block carries the table entry addressed by the top `ADDR_W` bits of P + k·F, taken modulo 2^`PHASE_W`.
- R3: Successive blocks continue one scalar oscillator: each base phase exceeds the one before it by `LANES`·F, so sample n of the stream is read at phase n·F.
- R4: A block whose base phase is the accumulator value held between edges t−1 and t appears on `samples_out` just after edge t+1.
- R5: A tuning word given with `ftw_load` at edge t applies to every lane of every block whose base phase is taken at edge t+1 or later. The phase does not jump at the switch.
- R6: `phase_clr` at edge t sets the accumulator to zero. The block formed at edge t+1 then has base phase 0.
- R7: A write (`wr_en`, `wr_addr`, `wr_data`) at an edge updates the entry in every lane copy. A read at that same edge still returns the old entry, and later reads return the new one.
- R8: Lane k occupies bits [14k+13:14k] of `samples_out`, so lane 0 is in the least significant 14 bits.
- R9: Phase arithmetic wraps modulo 2^`PHASE_W`. Tuning words at or above 2^(`PHASE_W`−1) therefore step the table backward or by half a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| ftw_in | input | PHASE_W | Frequency tuning word |
| ftw_load | input | 1 | Capture `ftw_in` at this edge |
| phase_clr | input | 1 | Return the accumulator to zero |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | ADDR_W | Table write address |
| wr_data | input | SAMPLE_W | Table write data |
| samples_out | output | LANES·SAMPLE_W | Packed samples, lane 0 in the low bits |
| samples_vld | output | 1 | Output word is valid |

## Verification
The assertions assume at least two lanes. They also assume that reset is held from the first clock edge, so that the lane phases always start from a known state. The phase-step properties are checked only when no reset or phase clear landed in the cycles they compare, and the stimulus places tuning-word loads and clears on isolated edges so that the checked windows occur. The bench fills the table only while its lane comparison is off, because the table starts out unknown. It then compares every lane against a scalar reference oscillator, including table rewrites on edges that also read.

// File: rtl/mdds_pkg.sv
package mdds_pkg;

    localparam int unsigned DEF_PHASE_W  = 48;
    localparam int unsigned DEF_ADDR_W   = 8;
    localparam int unsigned DEF_SAMPLE_W = 14;
    localparam int unsigned DEF_LANES    = 8;

    // Output pipeline fill state after reset.
    typedef enum logic [1:0] {
        FILL_IDLE = 2'd0,
        FILL_ONE  = 2'd1,
        FILL_FULL = 2'd2
    } fill_e;

    function automatic fill_e fill_next(input fill_e cur);
        case (cur)
            FILL_IDLE: return FILL_ONE;
            FILL_ONE:  return FILL_FULL;
            default:   return FILL_FULL;
        endcase
    endfunction

endpackage

// File: rtl/mdds_step_bank.sv
module mdds_step_bank #(
    parameter int unsigned PHASE_W = mdds_pkg::DEF_PHASE_W,
    parameter int unsigned LANES   = mdds_pkg::DEF_LANES
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [PHASE_W-1:0]               ftw_in,
    input  logic                             ftw_load,
    output logic [LANES-1:0][PHASE_W-1:0]    lane_off,
    output logic [PHASE_W-1:0]               block_step
);
    localparam logic [PHASE_W-1:0] LANE_MULT = PHASE_W'(LANES);

    for (genvar k = 0; k < LANES; k++) begin : g_off
        localparam logic [PHASE_W-1:0] K_MULT = PHASE_W'(k);
        always_ff @(posedge clk) begin
            if (rst) begin
                lane_off[k] <= '0;
            end else if (ftw_load) begin
                lane_off[k] <= K_MULT * ftw_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            block_step <= '0;
        end else if (ftw_load) begin
            block_step <= LANE_MULT * ftw_in;
        end
    end
endmodule

// File: rtl/mdds_phase_acc.sv
module mdds_phase_acc #(
    parameter int unsigned PHASE_W = mdds_pkg::DEF_PHASE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               phase_clr,
    input  logic [PHASE_W-1:0] block_step,
    output logic [PHASE_W-1:0] acc
);
    always_ff @(posedge clk) begin
        if (rst || phase_clr) begin
            acc <= '0;
        end else begin
            acc <= acc + block_step;
        end
    end
endmodule

// File: rtl/mdds_lane.sv
module mdds_lane #(
    parameter int unsigned PHASE_W  = mdds_pkg::DEF_PHASE_W,
    parameter int unsigned ADDR_W   = mdds_pkg::DEF_ADDR_W,
    parameter int unsigned SAMPLE_W = mdds_pkg::DEF_SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PHASE_W-1:0]  base,
    input  logic [PHASE_W-1:0]  offset,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [SAMPLE_W-1:0] wr_data,
    output logic [PHASE_W-1:0]  phase,
    output logic [SAMPLE_W-1:0] sample
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [SAMPLE_W-1:0] table_q [DEPTH];
    logic [ADDR_W-1:0]   rd_addr;

    assign rd_addr = phase[PHASE_W-1 -: ADDR_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else begin
            phase <= base + offset;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            table_q[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sample <= '0;
        end else begin
            sample <= table_q[rd_addr];
        end
    end
endmodule

// File: rtl/mdds_multiphase.sv
module mdds_multiphase #(
    parameter int unsigned PHASE_W  = mdds_pkg::DEF_PHASE_W,
    parameter int unsigned ADDR_W   = mdds_pkg::DEF_ADDR_W,
    parameter int unsigned SAMPLE_W = mdds_pkg::DEF_SAMPLE_W,
    parameter int unsigned LANES    = mdds_pkg::DEF_LANES
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [PHASE_W-1:0]          ftw_in,
    input  logic                        ftw_load,
    input  logic                        phase_clr,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [SAMPLE_W-1:0]         wr_data,
    output logic [LANES*SAMPLE_W-1:0]   samples_out,
    output logic                        samples_vld
);
    import mdds_pkg::*;

    logic [LANES-1:0][PHASE_W-1:0] lane_off;
    logic [LANES-1:0][PHASE_W-1:0] lane_ph;
    logic [PHASE_W-1:0]            block_step;
    logic [PHASE_W-1:0]            acc;
    fill_e                         fill_q;

    mdds_step_bank #(.PHASE_W(PHASE_W), .LANES(LANES)) u_steps (
        .clk        (clk),
        .rst        (rst),
        .ftw_in     (ftw_in),
        .ftw_load   (ftw_load),
        .lane_off   (lane_off),
        .block_step (block_step)
    );

    mdds_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
        .clk        (clk),
        .rst        (rst),
        .phase_clr  (phase_clr),
        .block_step (block_step),
        .acc        (acc)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        mdds_lane #(
            .PHASE_W  (PHASE_W),
            .ADDR_W   (ADDR_W),
            .SAMPLE_W (SAMPLE_W)
        ) u_lane (
            .clk     (clk),
            .rst     (rst),
            .base    (acc),
            .offset  (lane_off[k]),
            .wr_en   (wr_en),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .phase   (lane_ph[k]),
            .sample  (samples_out[k*SAMPLE_W +: SAMPLE_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q <= FILL_IDLE;
        end else begin
            fill_q <= fill_next(fill_q);
        end
    end

    assign samples_vld = (fill_q == FILL_FULL);
endmodule

// File: rtl/mdds_checker.sv
module mdds_checker #(
    parameter int unsigned PHASE_W  = mdds_pkg::DEF_PHASE_W,
    parameter int unsigned SAMPLE_W = mdds_pkg::DEF_SAMPLE_W,
    parameter int unsigned LANES    = mdds_pkg::DEF_LANES
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          phase_clr,
    input logic                          ftw_load,
    input logic [LANES-1:0][PHASE_W-1:0] lane_ph,
    input logic [LANES*SAMPLE_W-1:0]     samples_out,
    input logic                          samples_vld
);
    localparam logic [PHASE_W-1:0] LANE_MULT = PHASE_W'(LANES);

    AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!samples_vld && samples_out == '0)); // R1

    AST_VLD_FILL: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(!rst, 2)) |-> samples_vld); // R1

    AST_CLR_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        ($past(phase_clr, 2) && $past(!rst, 2) && $past(!rst)) |-> lane_ph[0] == '0); // R6

    if (LANES >= 2) begin : g_multi
        logic [PHASE_W-1:0] spacing;
        assign spacing = lane_ph[1] - lane_ph[0];

        for (genvar k = 2; k < LANES; k++) begin : g_space
            AST_LANE_SPACING: assert property (@(posedge clk) disable iff (rst)
                (lane_ph[k] - lane_ph[k-1]) == spacing); // R2
        end

        AST_BLOCK_STEP: assert property (@(posedge clk) disable iff (rst)
            ($past(!rst) && $past(!rst, 2) && !$past(phase_clr, 2))
            |-> (lane_ph[0] - $past(lane_ph[0])) == LANE_MULT * $past(spacing)); // R3

        AST_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
            ($past(!rst) && $past(!rst, 2) && !$past(ftw_load, 2))
            |-> spacing == $past(spacing)); // R5
    end
endmodule

bind mdds_multiphase mdds_checker #(
    .PHASE_W  (PHASE_W),
    .SAMPLE_W (SAMPLE_W),
    .LANES    (LANES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .phase_clr   (phase_clr),
    .ftw_load    (ftw_load),
    .lane_ph     (lane_ph),
    .samples_out (samples_out),
    .samples_vld (samples_vld)
);

// File: tb/mdds_multiphase_tb.sv
module mdds_multiphase_tb;
    localparam int PW    = 48;
    localparam int AW    = 8;
    localparam int SW    = 14;
    localparam int NL    = 8;
    localparam int SHIFT = PW - AW;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [PW-1:0]     ftw_in = '0;
    logic              ftw_load = 1'b0;
    logic              phase_clr = 1'b0;
    logic              wr_en = 1'b0;
    logic [AW-1:0]     wr_addr = '0;
    logic [SW-1:0]     wr_data = '0;
    logic [NL*SW-1:0]  samples_out;
    logic              samples_vld;

    always #10 clk = ~clk;

    mdds_multiphase #(.PHASE_W(PW), .ADDR_W(AW), .SAMPLE_W(SW), .LANES(NL)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .ftw_in      (ftw_in),
        .ftw_load    (ftw_load),
        .phase_clr   (phase_clr),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .samples_out (samples_out),
        .samples_vld (samples_vld)
    );

    int  checks   = 0;
    int  failures = 0;
    bit  done     = 1'b0;
    bit  lanes_on = 1'b0;

    // Bench-side reference: table image and scalar oscillator state.
    logic [SW-1:0] tbl [1<<AW];
    logic [PW-1:0] m_acc, m_f, fb, ff, ob, of_;
    logic [SW-1:0] exp_s [NL];
    int            vcnt;

    function automatic logic [SW-1:0] tval(input int a);
        return SW'((a * 613 + 29) ^ (a << 5));
    endfunction

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
        end
    endtask

    task automatic cyc(input string tag, input bit clr = 0, input bit ld = 0,
                       input logic [PW-1:0] f = '0, input bit we = 0,
                       input logic [AW-1:0] wa = '0, input logic [SW-1:0] wd = '0);
        phase_clr = clr; ftw_load = ld; ftw_in = f;
        wr_en = we; wr_addr = wa; wr_data = wd;
        @(posedge clk);
        if (rst) begin
            m_acc = '0; m_f = '0; fb = '0; ff = '0; ob = '0; of_ = '0; vcnt = 0;
        end else begin
            ob = fb; of_ = ff;
            for (int k = 0; k < NL; k++) begin
                exp_s[k] = tbl[AW'((ob + PW'(k) * of_) >> SHIFT)];
            end
            fb = m_acc; ff = m_f;
            m_acc = clr ? '0 : m_acc + PW'(NL) * m_f;
            if (ld) m_f = f;
            if (we) tbl[wa] = wd;
            if (vcnt < 2) vcnt++;
        end
        #5;
        if (rst) begin
            chk("R1 valid during reset", 64'(samples_vld), 64'd0);
            chk("R1 samples during reset", 64'(samples_out == '0), 64'd1);
        end else if (vcnt < 2) begin
            chk("R1 valid while filling", 64'(samples_vld), 64'd0);
        end else begin
            chk({tag, " valid"}, 64'(samples_vld), 64'd1);
            if (lanes_on) begin
                for (int k = 0; k < NL; k++) begin
                    chk($sformatf("%s R8 lane %0d", tag, k),
                        64'(samples_out[k*SW +: SW]), 64'(exp_s[k]));
                end
            end
        end
    endtask

    task automatic run(input string tag, input int n);
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < (1 << AW); a++) tbl[a] = '0;
        rst = 1'b1;
        run("R1", 3);
        rst = 1'b0;

        // Table load; lanes hold unknown contents until written.
        for (int a = 0; a < (1 << AW); a++) cyc("R7", 0, 0, '0, 1, AW'(a), tval(a));
        lanes_on = 1'b1;

        cyc("R4", 1, 1, PW'(1) << SHIFT);
        run("R4", 4);
        run("R2", 36);

        cyc("R3", 1, 1, 48'h0123_4567_89AB);
        run("R3", 40);

        cyc("R9", 1, 1, 48'hFFFF_FFFF_FFFF);
        run("R9", 20);
        cyc("R9", 0, 1, 48'h8000_0000_0000);
        run("R9", 10);
        cyc("R9", 0, 1, 48'h7FFF_0000_0001);
        run("R9", 20);

        cyc("R2", 0, 1, '0);
        run("R2", 10);

        cyc("R5", 0, 1, 48'h0000_3300_0007);
        run("R5", 6);
        cyc("R5", 0, 1, 48'h0012_0000_0000);
        run("R5", 20);

        cyc("R6", 1, 0);
        run("R6", 10);
        cyc("R6", 1, 1, '0);
        run("R6", 6);

        cyc("R7", 1, 1, PW'(1) << SHIFT);
        for (int i = 0; i < 64; i++) cyc("R7", 0, 0, '0, 1, AW'(i * 4), tval(i) ^ 14'h2AAA);
        run("R7", 40);

        rst = 1'b1;
        run("R1", 2);
        rst = 1'b0;
        run("R1", 6);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule